// File: doc/BRIEF.md
# Accelerator control and interrupt register block

This block is the host-facing control point of a small compute engine. Host software reaches it through an AXI4-Lite slave port. Through that port software starts a job, watches a busy flag, aborts a running job with a software reset, and services offload requests. In an offload request the engine stops mid-job, shows a nonzero opcode, and waits until the host has done the work and writes a resume command.

Two event sources feed a small interrupt controller: job end and offload request. Each source has a status bit, an enable bit and a write-one-to-clear acknowledge. The interrupt output is a level signal. On the engine side the block drives one-cycle start, abort and resume pulses. It takes in a done pulse and an offload request pulse that carries an opcode.

Top module: `acc_ctrl_regs`

The register map uses word index k at byte address 4*k:

| Index | Name | Behaviour |
|---|---|---|
| 0 | control | Write bit 0 to start, bit 1 to reset. Read bit 0 is busy. |
| 1 | irq enable | Read/write, 2 bits |
| 2 | irq status | Read only. Bit 0 is job end, bit 1 is offload. |
| 3 | irq acknowledge | Write only, reads 0 |
| 4 | offload opcode | Read only |
| 5 | offload resume | Write only, bit 0. Reads 0. |

## Requirements
- R1: The byte address of a register is its word index times 4, using the map above. Reads of any other address, and of the write-only indices 3 and 5, return 0. Every read response and write response is OKAY (0).
- R2: After the active-low reset rst_ni, the busy flag, enable, status and opcode all read 0, and irq_o is low.
- R3: Writing control with bit 0 set while idle gives exactly one one-cycle eng_start_o pulse and sets busy (control bit 0 reads 1). A start written while busy gives no pulse.
- R4: An eng_done_i pulse while busy clears busy and sets status bit 0. An eng_done_i pulse while idle changes nothing.
- R5: An eng_req_i pulse while busy sets status bit 1 and latches eng_opcode_i. Index 4 then reads that opcode until the request is resolved. With no request pending, index 4 reads 0.
- R6: Writing index 5 with bit 0 set while a request is pending gives exactly one eng_resume_o pulse, and index 4 then reads 0. With no request pending, the write has no effect.
- R7: Writing control with bit 1 set while busy gives one eng_abort_o pulse, clears busy and the pending request, and sets status bit 0. A later start runs a new job. The same write while idle gives no pulse and leaves status at 0.
- R8: Writing a mask to index 3 clears the matching status bits. If an event sets a bit in the same cycle that an acknowledge clears it, the bit stays set.
- R9: irq_o is high exactly when some status bit is set and its enable bit is set. Only the low 2 bits of the enable register are stored.
- R10: A write takes effect and its B response is given only after both the AW and W handshakes have completed, in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_awaddr_i | input | ADDR_W | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | DATA_W | Write data |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | ADDR_W | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | DATA_W | Read data |
| s_rresp_o | output | 2 | Read response |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| eng_start_o | output | 1 | Job start pulse |
| eng_abort_o | output | 1 | Job abort pulse |
| eng_done_i | input | 1 | Job finished pulse |
| eng_req_i | input | 1 | Offload request pulse |
| eng_opcode_i | input | OPCODE_W | Opcode, valid with eng_req_i |
| eng_resume_o | output | 1 | Resume pulse to engine |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that eng_done_i and eng_req_i are single-cycle pulses. They also assume that the engine sends no new request until it has been resumed, and that the AXI master keeps valid high until ready is seen. The stub engine in the bench pulses done and request for exactly one cycle, only from directed steps. It sends a request only while a job is running and nothing is pending. The bench AXI tasks hold each valid signal until its handshake edge.

// File: rtl/acc_ctrl_pkg.sv
package acc_ctrl_pkg;
  localparam int unsigned IDX_CTRL     = 0;
  localparam int unsigned IDX_IRQ_EN   = 1;
  localparam int unsigned IDX_IRQ_STAT = 2;
  localparam int unsigned IDX_IRQ_ACK  = 3;
  localparam int unsigned IDX_OFF_OP   = 4;
  localparam int unsigned IDX_OFF_RES  = 5;

  localparam int unsigned N_IRQ       = 2;
  localparam int unsigned IRQ_JOB_END = 0;
  localparam int unsigned IRQ_OFFLOAD = 1;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/axil_slave_if.sv
module axil_slave_if #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  import acc_ctrl_pkg::*;

  logic              aw_held_q, w_held_q, bvalid_q, rvalid_q;
  logic [IDX_W-1:0]  aw_idx_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  assign awready_o = !aw_held_q && !bvalid_q;
  assign wready_o  = !w_held_q && !bvalid_q;
  assign wr_en_o   = aw_held_q && w_held_q && !bvalid_q;
  assign wr_idx_o  = aw_idx_q;
  assign wr_data_o = wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_held_q <= 1'b0;
      w_held_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      aw_idx_q  <= '0;
      wdata_q   <= '0;
    end else begin
      if (awvalid_i && awready_o) begin
        aw_held_q <= 1'b1;
        aw_idx_q  <= awaddr_i[ADDR_W-1:2];
      end
      if (wvalid_i && wready_o) begin
        w_held_q <= 1'b1;
        wdata_q  <= wdata_i;
      end
      if (wr_en_o) begin
        aw_held_q <= 1'b0;
        w_held_q  <= 1'b0;
        bvalid_q  <= 1'b1;
      end else if (bvalid_q && bready_i) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  assign rd_idx_o  = araddr_i[ADDR_W-1:2];
  assign arready_o = !rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid_i && arready_o) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_data_i;
    end else if (rvalid_q && rready_i) begin
      rvalid_q <= 1'b0;
    end
  end

  assign bvalid_o = bvalid_q;
  assign bresp_o  = RESP_OKAY;
  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
  assign rresp_o  = RESP_OKAY;

  AST_B_AFTER_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bvalid_q) |-> $past(aw_held_q && w_held_q)) else $error("b early"); // R10
  AST_R_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_q && !rready_i) |=> (rvalid_q && $stable(rdata_q))) else $error("r drop"); // R1
endmodule

// File: rtl/job_seq.sv
module job_seq #(
  parameter int unsigned OPCODE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_req_i,
  input  logic                swrst_req_i,
  input  logic                resume_req_i,
  input  logic                done_i,
  input  logic                req_i,
  input  logic [OPCODE_W-1:0] opcode_i,
  output logic                start_o,
  output logic                abort_o,
  output logic                resume_o,
  output logic                busy_o,
  output logic [OPCODE_W-1:0] opcode_o,
  output logic                end_evt_o,
  output logic                req_evt_o
);
  logic busy_q, pend_q;
  logic [OPCODE_W-1:0] opcode_q;
  logic start_go, abort_go, done_go, req_go, resume_go;

  assign abort_go  = swrst_req_i && busy_q;
  assign start_go  = start_req_i && !busy_q && !swrst_req_i;
  assign done_go   = done_i && busy_q && !abort_go;
  assign req_go    = req_i && busy_q && !pend_q && !abort_go;
  assign resume_go = resume_req_i && pend_q && !abort_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      pend_q   <= 1'b0;
      opcode_q <= '0;
      start_o  <= 1'b0;
      abort_o  <= 1'b0;
      resume_o <= 1'b0;
    end else begin
      start_o  <= start_go;
      abort_o  <= abort_go;
      resume_o <= resume_go;
      if (abort_go || done_go)  busy_q <= 1'b0;
      else if (start_go)        busy_q <= 1'b1;
      if (abort_go || done_go || resume_go) begin
        pend_q   <= 1'b0;
        opcode_q <= '0;
      end else if (req_go) begin
        pend_q   <= 1'b1;
        opcode_q <= opcode_i;
      end
    end
  end

  assign busy_o    = busy_q;
  assign opcode_o  = opcode_q;
  assign end_evt_o = done_go || abort_go;
  assign req_evt_o = req_go;

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o) else $error("start width"); // R3
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_q) else $error("start not busy"); // R3
  AST_ABORT_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> ($past(busy_q) && !busy_q)) else $error("abort idle"); // R7
  AST_RESUME_ONLY_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> ($past(pend_q) && !pend_q)) else $error("resume stray"); // R6
endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         ack_we_i,
  input  logic [N-1:0] ack_mask_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_data_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] stat_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_data_i;
  end

  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         stat_q[b] <= 1'b0;
      else if (set_i[b])                   stat_q[b] <= 1'b1;
      else if (ack_we_i && ack_mask_i[b])  stat_q[b] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[b] |=> stat_q[b]) else $error("set lost"); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_we_i && ack_mask_i[b] && !set_i[b]) |=> !stat_q[b]) else $error("ack ignored"); // R8
  end

  assign irq_o  = |(stat_q & en_q);
  assign stat_o = stat_q;
  assign en_o   = en_q;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o) else $error("irq masked"); // R9
endmodule

// File: rtl/acc_ctrl_regs.sv
module acc_ctrl_regs #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned OPCODE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   s_awaddr_i,
  input  logic                s_awvalid_i,
  output logic                s_awready_o,
  input  logic [DATA_W-1:0]   s_wdata_i,
  input  logic                s_wvalid_i,
  output logic                s_wready_o,
  output logic [1:0]          s_bresp_o,
  output logic                s_bvalid_o,
  input  logic                s_bready_i,
  input  logic [ADDR_W-1:0]   s_araddr_i,
  input  logic                s_arvalid_i,
  output logic                s_arready_o,
  output logic [DATA_W-1:0]   s_rdata_o,
  output logic [1:0]          s_rresp_o,
  output logic                s_rvalid_o,
  input  logic                s_rready_i,
  output logic                eng_start_o,
  output logic                eng_abort_o,
  input  logic                eng_done_i,
  input  logic                eng_req_i,
  input  logic [OPCODE_W-1:0] eng_opcode_i,
  output logic                eng_resume_o,
  output logic                irq_o
);
  import acc_ctrl_pkg::*;
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              busy, end_evt, req_evt;
  logic [OPCODE_W-1:0] opcode;
  logic [N_IRQ-1:0]  stat, en, set_vec;
  logic              hit_ctrl, hit_en, hit_ack, hit_res;

  axil_slave_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_axil (
    .clk_i, .rst_ni,
    .awaddr_i(s_awaddr_i), .awvalid_i(s_awvalid_i), .awready_o(s_awready_o),
    .wdata_i(s_wdata_i), .wvalid_i(s_wvalid_i), .wready_o(s_wready_o),
    .bresp_o(s_bresp_o), .bvalid_o(s_bvalid_o), .bready_i(s_bready_i),
    .araddr_i(s_araddr_i), .arvalid_i(s_arvalid_i), .arready_o(s_arready_o),
    .rdata_o(s_rdata_o), .rresp_o(s_rresp_o), .rvalid_o(s_rvalid_o),
    .rready_i(s_rready_i),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .rd_idx_o(rd_idx), .rd_data_i(rd_data)
  );

  assign hit_ctrl = wr_en && (wr_idx == IDX_W'(IDX_CTRL));
  assign hit_en   = wr_en && (wr_idx == IDX_W'(IDX_IRQ_EN));
  assign hit_ack  = wr_en && (wr_idx == IDX_W'(IDX_IRQ_ACK));
  assign hit_res  = wr_en && (wr_idx == IDX_W'(IDX_OFF_RES));

  job_seq #(.OPCODE_W(OPCODE_W)) u_seq (
    .clk_i, .rst_ni,
    .start_req_i(hit_ctrl && wr_data[0]),
    .swrst_req_i(hit_ctrl && wr_data[1]),
    .resume_req_i(hit_res && wr_data[0]),
    .done_i(eng_done_i), .req_i(eng_req_i), .opcode_i(eng_opcode_i),
    .start_o(eng_start_o), .abort_o(eng_abort_o), .resume_o(eng_resume_o),
    .busy_o(busy), .opcode_o(opcode),
    .end_evt_o(end_evt), .req_evt_o(req_evt)
  );

  always_comb begin
    set_vec = '0;
    set_vec[IRQ_JOB_END] = end_evt;
    set_vec[IRQ_OFFLOAD] = req_evt;
  end

  irq_unit #(.N(N_IRQ)) u_irq (
    .clk_i, .rst_ni,
    .set_i(set_vec),
    .ack_we_i(hit_ack), .ack_mask_i(wr_data[N_IRQ-1:0]),
    .en_we_i(hit_en), .en_data_i(wr_data[N_IRQ-1:0]),
    .stat_o(stat), .en_o(en), .irq_o(irq_o)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_idx)
      IDX_W'(IDX_CTRL):     rd_data[0] = busy;
      IDX_W'(IDX_IRQ_EN):   rd_data[N_IRQ-1:0] = en;
      IDX_W'(IDX_IRQ_STAT): rd_data[N_IRQ-1:0] = stat;
      IDX_W'(IDX_OFF_OP):   rd_data[OPCODE_W-1:0] = opcode;
      default:              rd_data = '0;
    endcase
  end

  AST_IRQ_LOW_NO_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat == '0) |-> !irq_o) else $error("irq spurious"); // R9
endmodule

// File: tb/sim_acc_ctrl_regs.sv
module sim_acc_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8, DATA_W = 32, OPCODE_W = 8;

  logic clk_i = 0, rst_ni = 0;
  logic [ADDR_W-1:0] awaddr = 0, araddr = 0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [DATA_W-1:0] wdata = 0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [DATA_W-1:0] rdata;
  logic start_p, abort_p, resume_p, irq;
  logic done_p = 0, req_p = 0;
  logic [OPCODE_W-1:0] opcode = 0;

  int n_chk = 0, n_err = 0;
  int n_start = 0, n_abort = 0, n_resume = 0;
  bit finished = 0;
  logic [DATA_W-1:0] rv;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  acc_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPCODE_W(OPCODE_W)) u0 (
    .clk_i, .rst_ni,
    .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
    .s_wdata_i(wdata), .s_wvalid_i(wvalid), .s_wready_o(wready),
    .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(bready),
    .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
    .s_rdata_o(rdata), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(rready),
    .eng_start_o(start_p), .eng_abort_o(abort_p), .eng_done_i(done_p),
    .eng_req_i(req_p), .eng_opcode_i(opcode), .eng_resume_o(resume_p), .irq_o(irq)
  );

  always @(posedge clk_i) begin
    if (start_p)  n_start++;
    if (abort_p)  n_abort++;
    if (resume_p) n_resume++;
  end

  // {index, write data, expected readback}
  localparam logic [19:0] VEC [6] = '{
    {4'd1, 8'h03, 8'h03}, {4'd1, 8'h05, 8'h01}, {4'd1, 8'h00, 8'h00},
    {4'd7, 8'hAA, 8'h00}, {4'd3, 8'hFF, 8'h00}, {4'd15, 8'h01, 8'h00}};

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [DATA_W-1:0] d);
    @(negedge clk_i);
    awaddr = ADDR_W'(idx * 4); wdata = d; awvalid = 1; wvalid = 1;
    do @(posedge clk_i); while (!(awready && wready));
    @(negedge clk_i);
    awvalid = 0; wvalid = 0;
    while (!bvalid) @(negedge clk_i);
    chk("R1 bresp", 32'(bresp), 0);
    bready = 1;
    @(negedge clk_i);
    bready = 0;
  endtask

  task automatic rd(input int idx, output logic [DATA_W-1:0] d);
    @(negedge clk_i);
    araddr = ADDR_W'(idx * 4); arvalid = 1;
    do @(posedge clk_i); while (!arready);
    @(negedge clk_i);
    arvalid = 0;
    while (!rvalid) @(negedge clk_i);
    d = rdata;
    chk("R1 rresp", 32'(rresp), 0);
    rready = 1;
    @(negedge clk_i);
    rready = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk_i); done_p = 1;
    @(negedge clk_i); done_p = 0;
  endtask

  task automatic pulse_req(input logic [OPCODE_W-1:0] op);
    @(negedge clk_i); req_p = 1; opcode = op;
    @(negedge clk_i); req_p = 0; opcode = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R2 reset state
    @(negedge clk_i);
    chk("R2 irq", 32'(irq), 0);
    rd(0, rv); chk("R2 ctrl", rv, 0);
    rd(1, rv); chk("R2 en", rv, 0);
    rd(2, rv); chk("R2 stat", rv, 0);
    rd(4, rv); chk("R2 opcode", rv, 0);

    // R1 R9 table: decode, width, unmapped and write-only reads
    for (int i = 0; i < 6; i++) begin
      wr(int'(VEC[i][19:16]), 32'(VEC[i][15:8]));
      rd(int'(VEC[i][19:16]), rv);
      chk("R1 R9 table", rv, 32'(VEC[i][7:0]));
    end

    // R7 soft reset while idle
    wr(0, 2);
    rd(2, rv); chk("R7 idle stat", rv, 0);
    chk("R7 idle abort", n_abort, 0);

    // R3 start, then start while busy
    wr(1, 3);
    wr(0, 1);
    chk("R3 start pulses", n_start, 1);
    rd(0, rv); chk("R3 busy", rv, 1);
    wr(0, 1);
    chk("R3 start while busy", n_start, 1);

    // R5 offload request
    rd(4, rv); chk("R5 idle opcode", rv, 0);
    pulse_req(8'h5A);
    rd(2, rv); chk("R5 stat", rv, 2);
    rd(4, rv); chk("R5 opcode", rv, 32'h5A);
    chk("R9 irq offload", 32'(irq), 1);

    // R6 resume, R8 ack
    wr(5, 1);
    chk("R6 resume pulse", n_resume, 1);
    rd(4, rv); chk("R6 opcode cleared", rv, 0);
    wr(3, 2);
    rd(2, rv); chk("R8 ack", rv, 0);
    chk("R9 irq low", 32'(irq), 0);

    // R4 done
    pulse_done();
    rd(0, rv); chk("R4 busy clear", rv, 0);
    rd(2, rv); chk("R4 stat", rv, 1);
    chk("R9 irq done", 32'(irq), 1);
    wr(1, 2);
    chk("R9 masked", 32'(irq), 0);
    wr(1, 3);
    wr(3, 1);

    // R4 done while idle ignored; R6 resume without pending ignored
    pulse_done();
    rd(2, rv); chk("R4 idle done", rv, 0);
    wr(5, 1);
    chk("R6 stray resume", n_resume, 1);

    // R7 soft reset mid-offload
    wr(0, 1);
    pulse_req(8'h33);
    wr(0, 2);
    chk("R7 abort pulse", n_abort, 1);
    rd(0, rv); chk("R7 busy clear", rv, 0);
    rd(4, rv); chk("R7 pending clear", rv, 0);
    rd(2, rv); chk("R7 stat", rv, 3);
    wr(3, 3);
    wr(0, 1);
    chk("R7 fresh start", n_start, 3);
    rd(0, rv); chk("R7 fresh busy", rv, 1);
    pulse_done();
    rd(2, rv); chk("R4 stat again", rv, 1);

    // R8 set coincides with ack; R10 AW before W
    wr(0, 1);
    @(negedge clk_i);
    awaddr = ADDR_W'(3 * 4); awvalid = 1;
    @(negedge clk_i);
    awvalid = 0;
    repeat (2) @(negedge clk_i);
    chk("R10 no b without w", 32'(bvalid), 0);
    rd(2, rv); chk("R10 no write without w", rv, 1);
    @(negedge clk_i);
    wdata = 1; wvalid = 1;
    @(negedge clk_i);
    wvalid = 0; done_p = 1;
    @(negedge clk_i);
    done_p = 0;
    while (!bvalid) @(negedge clk_i);
    bready = 1;
    @(negedge clk_i);
    bready = 0;
    rd(2, rv); chk("R8 set wins", rv, 1);
    rd(0, rv); chk("R4 busy after coincident", rv, 0);

    finish_run();
  end
endmodule